// File: doc/BRIEF.md
# APB GPIO controller with edge and level interrupts

This block is a general purpose I/O controller that sits on an APB bus as a slave. It serves up to four ports of up to 32 lines each. Every port has an output data register and a direction register that drive the pad outputs and output enables, and a read-only view of its input pins after a two-flop synchroniser.

The first port (port A) also carries per-line interrupt logic. Each line can be enabled, masked, and set to edge or level sensitivity with a chosen polarity. Edge events are held in a status bit until software clears them by writing ones to an end-of-interrupt register. Each port A line can also route its input through an optional glitch filter. All masked status bits are ORed into a single interrupt output. A build parameter selects one of two address maps for the interrupt registers.

Top module: `gpio_apb_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_out` and `pin_oe` are all zeros and `irq_o` is low.
- R2: For port p (0 to 3), the output data register at byte address 0x0C*p drives `pin_out[32p+31:32p]`, and the direction register at 0x0C*p+4 drives `pin_oe` for the same slice. Both registers read back what was written.
- R3: For port p, the register at 0x50+4*p returns that port's pins through a two-flop synchroniser. Writes to it have no effect.
- R4: On port A with enable=1 and type=1 (edge), polarity 1 latches a status bit on a rising input and polarity 0 on a falling input. The bit stays set until it is cleared.
- R5: On port A with enable=1 and type=0 (level), the status bit is 1 while the synchronised input equals the polarity bit. An end-of-interrupt write does not clear it.
- R6: Writing ones to the end-of-interrupt register clears the matching latched edge bits. Zero bits leave their lines unchanged, and the register reads as 0.
- R7: The status register returns raw status ANDed with the inverse of the mask. The raw register (0x44, default map only) returns status before masking. A line whose enable bit is 0 contributes nothing.
- R8: `irq_o` is high exactly when any bit of the masked status is set.
- R9: With a line's debounce bit set (register 0x48), a synchronised input change is accepted only after it has stayed stable for two more clock cycles, so pulses of one or two cycles are ignored. With the bit clear, a one-cycle pulse is enough to latch an edge.
- R10: When a qualifying edge and an end-of-interrupt write of 1 land on the same line in the same cycle, the status bit is left set.
- R11: Default map: enable 0x30, mask 0x34, type 0x38, polarity 0x3C, status 0x40, raw 0x44, debounce 0x48, end-of-interrupt 0x4C. With ALT_MAP=1: mask 0x44, type 0x34, polarity 0x38, status 0x3C, end-of-interrupt 0x40. Enable, debounce and all port registers keep their addresses.
- R12: Reads from unmapped addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | System and bus clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pin_in | input | NUM_PORTS*PORT_WIDTH | Pin inputs, port p at slice p |
| pin_out | output | NUM_PORTS*PORT_WIDTH | Output data to the pads |
| pin_oe | output | NUM_PORTS*PORT_WIDTH | Output enables to the pads |
| irq_o | output | 1 | Combined port A interrupt |

## Verification
The bench builds two instances, both with four ports of 32 lines. One uses the default map and the other sets ALT_MAP=1, so both address layouts are tested against the same pin activity. With full-width ports, random 32-bit patterns cover every line's polarity, type, mask and clear combination at once. The same-cycle edge and clear case is timed by hand against the three-register input path.

// File: rtl/gpio_apb_pkg.sv
package gpio_apb_pkg;

  localparam int APB_AW    = 8;
  localparam int APB_DW    = 32;
  localparam int MAX_PORTS = 4;

  typedef enum logic [3:0] {
    REG_NONE, REG_DOUT, REG_DIR, REG_EXT, REG_INTEN, REG_MASK, REG_TYPE,
    REG_POL, REG_STAT, REG_RAW, REG_DEB, REG_EOI
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [1:0] port;
  } reg_sel_t;

  // Address decode; the port banks stride 0x0C, inputs stride 0x04.
  function automatic reg_sel_t decode_addr(input logic [APB_AW-1:0] addr,
                                           input bit alt, input int nports);
    reg_sel_t s;
    s.kind = REG_NONE;
    s.port = '0;
    for (int p = 0; p < MAX_PORTS; p++) begin
      if (p < nports) begin
        if (addr == APB_AW'(12 * p))      begin s.kind = REG_DOUT; s.port = 2'(p); end
        if (addr == APB_AW'(12 * p + 4))  begin s.kind = REG_DIR;  s.port = 2'(p); end
        if (addr == APB_AW'(80 + 4 * p))  begin s.kind = REG_EXT;  s.port = 2'(p); end
      end
    end
    if (!alt) begin
      case (addr)
        8'h30: s.kind = REG_INTEN;
        8'h34: s.kind = REG_MASK;
        8'h38: s.kind = REG_TYPE;
        8'h3C: s.kind = REG_POL;
        8'h40: s.kind = REG_STAT;
        8'h44: s.kind = REG_RAW;
        8'h48: s.kind = REG_DEB;
        8'h4C: s.kind = REG_EOI;
        default: ;
      endcase
    end else begin
      case (addr)
        8'h30: s.kind = REG_INTEN;
        8'h34: s.kind = REG_TYPE;
        8'h38: s.kind = REG_POL;
        8'h3C: s.kind = REG_STAT;
        8'h40: s.kind = REG_EOI;
        8'h44: s.kind = REG_MASK;
        8'h48: s.kind = REG_DEB;
        default: ;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] s,
  input  logic [W-1:0] db_en,
  output logic [W-1:0] q
);
  logic [W-1:0] hist1_q, hist2_q, filt_q;
  logic [W-1:0] steady, take;

  // A value is taken once it matches the two samples behind it.
  function automatic logic [W-1:0] steady_bits(input logic [W-1:0] a,
                                               input logic [W-1:0] b,
                                               input logic [W-1:0] c);
    return ~(a ^ b) & ~(b ^ c);
  endfunction

  assign steady = steady_bits(s, hist1_q, hist2_q);
  assign take   = ~db_en | steady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist1_q <= '0;
      hist2_q <= '0;
      filt_q  <= '0;
    end else begin
      hist1_q <= s;
      hist2_q <= hist1_q;
      filt_q  <= (filt_q & ~take) | (s & take);
    end
  end

  assign q = (filt_q & db_en) | (s & ~db_en);
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] v,
  input  logic [W-1:0] en,
  input  logic [W-1:0] typ,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] eoi_clr,
  output logic [W-1:0] edge_hit,
  output logic [W-1:0] edge_pend,
  output logic [W-1:0] raw,
  output logic [W-1:0] status,
  output logic         irq
);
  logic [W-1:0] prev_q, edge_q;

  function automatic logic [W-1:0] edge_events(input logic [W-1:0] cur,
                                               input logic [W-1:0] old,
                                               input logic [W-1:0] p);
    return (p & cur & ~old) | (~p & ~cur & old);
  endfunction

  function automatic logic [W-1:0] level_active(input logic [W-1:0] e,
                                                input logic [W-1:0] t,
                                                input logic [W-1:0] p,
                                                input logic [W-1:0] cur);
    return e & ~t & ~(cur ^ p);
  endfunction

  // A new edge outranks a clear on the same line.
  function automatic logic [W-1:0] next_pend(input logic [W-1:0] pend,
                                             input logic [W-1:0] hit,
                                             input logic [W-1:0] clr);
    return (pend & ~clr) | hit;
  endfunction

  assign edge_hit = en & typ & edge_events(v, prev_q, pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= v;
      edge_q <= next_pend(edge_q, edge_hit, eoi_clr) & en;
    end
  end

  assign edge_pend = edge_q;
  assign raw       = (edge_q & typ) | level_active(en, typ, pol, v);
  assign status    = raw & ~mask;
  assign irq       = |status;
endmodule

// File: rtl/gpio_apb_ctrl.sv
module gpio_apb_ctrl
  import gpio_apb_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int PORT_WIDTH = 32,
  parameter bit ALT_MAP    = 1'b0
) (
  input  logic                            pclk,
  input  logic                            presetn,
  input  logic                            psel,
  input  logic                            penable,
  input  logic                            pwrite,
  input  logic [APB_AW-1:0]               paddr,
  input  logic [APB_DW-1:0]               pwdata,
  output logic [APB_DW-1:0]               prdata,
  input  logic [NUM_PORTS*PORT_WIDTH-1:0] pin_in,
  output logic [NUM_PORTS*PORT_WIDTH-1:0] pin_out,
  output logic [NUM_PORTS*PORT_WIDTH-1:0] pin_oe,
  output logic                            irq_o
);
  localparam int W = PORT_WIDTH;

  reg_sel_t     sel;
  logic         wr_en;
  logic [W-1:0] wdata;
  logic [W-1:0] dout_v [NUM_PORTS];
  logic [W-1:0] dir_v  [NUM_PORTS];
  logic [W-1:0] ext_s  [NUM_PORTS];

  logic [W-1:0] int_en_q, int_mask_q, int_type_q, int_pol_q, deb_q;
  logic [W-1:0] eoi_clr, port_a_v;
  logic [W-1:0] edge_hit, edge_pend, raw_status, int_status;
  logic [W-1:0] rd_w;

  assign sel   = decode_addr(paddr, ALT_MAP, NUM_PORTS);
  assign wr_en = psel & penable & pwrite;
  assign wdata = pwdata[W-1:0];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [W-1:0] dout_q, dir_q;

    always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
        dout_q <= '0;
        dir_q  <= '0;
      end else if (wr_en && sel.port == 2'(p)) begin
        if (sel.kind == REG_DOUT) dout_q <= wdata;
        if (sel.kind == REG_DIR)  dir_q  <= wdata;
      end
    end

    gpio_sync #(.W(W)) u_sync (
      .clk   (pclk),
      .rst_n (presetn),
      .d     (pin_in[p*W +: W]),
      .q     (ext_s[p])
    );

    assign dout_v[p]          = dout_q;
    assign dir_v[p]           = dir_q;
    assign pin_out[p*W +: W]  = dout_q;
    assign pin_oe[p*W +: W]   = dir_q;
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      int_en_q   <= '0;
      int_mask_q <= '0;
      int_type_q <= '0;
      int_pol_q  <= '0;
      deb_q      <= '0;
    end else if (wr_en) begin
      case (sel.kind)
        REG_INTEN: int_en_q   <= wdata;
        REG_MASK:  int_mask_q <= wdata;
        REG_TYPE:  int_type_q <= wdata;
        REG_POL:   int_pol_q  <= wdata;
        REG_DEB:   deb_q      <= wdata;
        default: ;
      endcase
    end
  end

  assign eoi_clr = (wr_en && sel.kind == REG_EOI) ? wdata : '0;

  gpio_debounce #(.W(W)) u_deb (
    .clk   (pclk),
    .rst_n (presetn),
    .s     (ext_s[0]),
    .db_en (deb_q),
    .q     (port_a_v)
  );

  gpio_irq_unit #(.W(W)) u_irq (
    .clk       (pclk),
    .rst_n     (presetn),
    .v         (port_a_v),
    .en        (int_en_q),
    .typ       (int_type_q),
    .pol       (int_pol_q),
    .mask      (int_mask_q),
    .eoi_clr   (eoi_clr),
    .edge_hit  (edge_hit),
    .edge_pend (edge_pend),
    .raw       (raw_status),
    .status    (int_status),
    .irq       (irq_o)
  );

  always_comb begin
    rd_w = '0;
    case (sel.kind)
      REG_DOUT:  rd_w = dout_v[sel.port];
      REG_DIR:   rd_w = dir_v[sel.port];
      REG_EXT:   rd_w = ext_s[sel.port];
      REG_INTEN: rd_w = int_en_q;
      REG_MASK:  rd_w = int_mask_q;
      REG_TYPE:  rd_w = int_type_q;
      REG_POL:   rd_w = int_pol_q;
      REG_STAT:  rd_w = int_status;
      REG_RAW:   rd_w = raw_status;
      REG_DEB:   rd_w = deb_q;
      default:   rd_w = '0;
    endcase
    prdata         = '0;
    prdata[W-1:0]  = rd_w;
  end
endmodule

// File: rtl/gpio_apb_chk.sv
module gpio_apb_chk #(
  parameter int W    = 32,
  parameter int OE_W = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq,
  input logic [OE_W-1:0] pin_oe,
  input logic [W-1:0]    edge_hit,
  input logic [W-1:0]    edge_pend,
  input logic [W-1:0]    eoi_clr,
  input logic [W-1:0]    en,
  input logic [W-1:0]    raw,
  input logic [W-1:0]    mask
);
  AST_OE_RESET: assert property (@(posedge clk) !rst_n |=> pin_oe == '0); // R1

  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((edge_pend & $past(edge_hit)) == $past(edge_hit))); // R4

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(edge_pend) & ~edge_pend & ~$past(eoi_clr) & $past(en)) == '0)); // R4

  AST_EOI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|(eoi_clr & ~edge_hit)) |=> ((edge_pend & $past(eoi_clr & ~edge_hit)) == '0)); // R6

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(eoi_clr & edge_hit)) |=>
      ((edge_pend & $past(eoi_clr & edge_hit)) == $past(eoi_clr & edge_hit))); // R10

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((raw & ~mask) != '0)); // R8
endmodule

bind gpio_apb_ctrl gpio_apb_chk #(
  .W    (PORT_WIDTH),
  .OE_W (NUM_PORTS*PORT_WIDTH)
) u_chk (
  .clk       (pclk),
  .rst_n     (presetn),
  .irq       (irq_o),
  .pin_oe    (pin_oe),
  .edge_hit  (edge_hit),
  .edge_pend (edge_pend),
  .eoi_clr   (eoi_clr),
  .en        (int_en_q),
  .raw       (raw_status),
  .mask      (int_mask_q)
);

// File: tb/test_gpio_apb_ctrl.sv
`timescale 1ns/1ps
module test_gpio_apb_ctrl;
  localparam int NP = 4;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel_d = 1'b0, psel_a = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata_d, prdata_a;
  logic [NP*PW-1:0] pin_in = '0;
  logic [NP*PW-1:0] pout_d, poe_d, pout_a, poe_a;
  logic irq_d, irq_a;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] exp_dout [NP];

  always #4 clk = ~clk;

  gpio_apb_ctrl i_gpio_apb_ctrl (
    .pclk(clk), .presetn(rst_n), .psel(psel_d), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_d),
    .pin_in(pin_in), .pin_out(pout_d), .pin_oe(poe_d), .irq_o(irq_d));

  gpio_apb_ctrl #(.ALT_MAP(1'b1)) i_gpio_apb_ctrl_alt (
    .pclk(clk), .presetn(rst_n), .psel(psel_a), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_a),
    .pin_in(pin_in), .pin_out(pout_a), .pin_oe(poe_a), .irq_o(irq_a));

  // Default-map addresses, restated here.
  function automatic logic [7:0] a_dout(input int p); return 8'(p * 12); endfunction
  function automatic logic [7:0] a_dir(input int p);  return 8'(p * 12 + 4); endfunction
  function automatic logic [7:0] a_ext(input int p);  return 8'(8'h50 + p * 4); endfunction
  localparam logic [7:0] A_EN = 8'h30, A_MASK = 8'h34, A_TYPE = 8'h38, A_POL = 8'h3C,
                         A_STAT = 8'h40, A_RAW = 8'h44, A_DEB = 8'h48, A_EOI = 8'h4C;

  function automatic logic [31:0] lvl_exp(input logic [31:0] e, input logic [31:0] p,
                                          input logic [31:0] v);
    return e & (v ~^ p);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input bit alt, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel_d = !alt; psel_a = alt; paddr = a; pwdata = d; pwrite = 1'b1; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel_d = 1'b0; psel_a = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input bit alt, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel_d = !alt; psel_a = alt; paddr = a; pwrite = 1'b0; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = alt ? prdata_a : prdata_d;
    @(negedge clk);
    psel_d = 1'b0; psel_a = 1'b0; penable = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd, v, pol, e, q, l, m, en2, lv;
    int unsigned seed;
    seed = $urandom(32'h1a2b3c);
    for (int p = 0; p < NP; p++) exp_dout[p] = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 pin_oe", poe_d[31:0] | poe_d[127:96], 32'h0);
    chk("R1 pin_out", pout_d[63:32], 32'h0);
    chk("R1 irq", {31'h0, irq_d}, 32'h0);
    apb_rd(0, a_dout(0), rd); chk("R1 dout0", rd, 32'h0);
    apb_rd(0, A_STAT, rd);    chk("R1 status", rd, 32'h0);

    // R2 port output and direction registers
    for (int i = 0; i < 8; i++) begin
      int p;
      logic [31:0] dv, rv;
      p = int'($urandom % NP);
      dv = $urandom; rv = $urandom;
      apb_wr(0, a_dout(p), dv); exp_dout[p] = dv;
      apb_wr(0, a_dir(p), rv);
      apb_rd(0, a_dout(p), rd); chk("R2 dout readback", rd, dv);
      apb_rd(0, a_dir(p), rd);  chk("R2 dir readback", rd, rv);
      chk("R2 pin_out slice", pout_d[p*PW +: PW], dv);
      chk("R2 pin_oe slice", poe_d[p*PW +: PW], rv);
    end

    // R3 synchronised input view, read-only
    for (int i = 0; i < 3; i++) begin
      logic [NP*PW-1:0] pv;
      pv = {$urandom, $urandom, $urandom, $urandom};
      @(negedge clk); pin_in = pv;
      idle(3);
      for (int p = 0; p < NP; p++) begin
        apb_rd(0, a_ext(p), rd); chk("R3 ext input", rd, pv[p*PW +: PW]);
      end
      apb_wr(0, a_ext(1), ~pv[63:32]);
      apb_rd(0, a_ext(1), rd); chk("R3 ext ignores write", rd, pv[63:32]);
    end
    @(negedge clk); pin_in = '0;
    idle(4);

    // R4 edge latching with polarity
    pol = $urandom; v = $urandom;
    apb_wr(0, A_EN, 32'hFFFF_FFFF);
    apb_wr(0, A_TYPE, 32'hFFFF_FFFF);
    apb_wr(0, A_POL, pol);
    apb_wr(0, A_EOI, 32'hFFFF_FFFF);
    @(negedge clk); pin_in[31:0] = v;
    idle(5);
    apb_rd(0, A_STAT, rd); chk("R4 rising edges", rd, v & pol);
    @(negedge clk); pin_in[31:0] = '0;
    idle(5);
    apb_rd(0, A_STAT, rd); chk("R4 falling edges add", rd, v);
    chk("R8 irq with edges", {31'h0, irq_d}, {31'h0, v != 0});

    // R6 write-one-to-clear
    e = $urandom;
    apb_wr(0, A_EOI, e);
    apb_rd(0, A_STAT, rd); chk("R6 partial clear", rd, v & ~e);
    apb_wr(0, A_EOI, 32'h0);
    apb_rd(0, A_STAT, rd); chk("R6 zero write no effect", rd, v & ~e);
    apb_rd(0, A_EOI, rd);  chk("R6 eoi reads zero", rd, 32'h0);
    apb_wr(0, A_EOI, 32'hFFFF_FFFF);

    // R5 level sensitivity
    q = $urandom; l = $urandom;
    apb_wr(0, A_TYPE, 32'h0);
    apb_wr(0, A_POL, q);
    @(negedge clk); pin_in[31:0] = l;
    idle(5);
    lv = lvl_exp(32'hFFFF_FFFF, q, l);
    apb_rd(0, A_STAT, rd); chk("R5 level status", rd, lv);
    apb_wr(0, A_EOI, 32'hFFFF_FFFF);
    apb_rd(0, A_STAT, rd); chk("R5 eoi no effect on level", rd, lv);

    // R7 mask and enable
    m = $urandom;
    apb_wr(0, A_MASK, m);
    apb_rd(0, A_STAT, rd); chk("R7 masked status", rd, lv & ~m);
    apb_rd(0, A_RAW, rd);  chk("R7 raw status", rd, lv);
    en2 = $urandom | 32'h1;
    apb_wr(0, A_EN, en2);
    apb_rd(0, A_STAT, rd); chk("R7 enable gates status", rd, lv & en2 & ~m);

    // R8 combined interrupt
    apb_wr(0, A_MASK, 32'hFFFF_FFFF);
    chk("R8 irq all masked", {31'h0, irq_d}, 32'h0);
    apb_wr(0, A_MASK, 32'h0);
    chk("R8 irq unmasked", {31'h0, irq_d}, {31'h0, (lv & en2) != 0});

    // R9 debounce filter on line 0
    @(negedge clk); pin_in[31:0] = '0;
    apb_wr(0, A_EN, 32'h1);
    apb_wr(0, A_TYPE, 32'h1);
    apb_wr(0, A_POL, 32'h1);
    apb_wr(0, A_DEB, 32'h1);
    idle(5);
    apb_wr(0, A_EOI, 32'hFFFF_FFFF);
    apb_rd(0, A_DEB, rd); chk("R9 debounce readback", rd, 32'h1);
    @(negedge clk); pin_in[0] = 1'b1;
    @(negedge clk); pin_in[0] = 1'b0;
    idle(6);
    apb_rd(0, A_STAT, rd); chk("R9 one-cycle pulse filtered", rd, 32'h0);
    @(negedge clk); pin_in[0] = 1'b1;
    idle(2); pin_in[0] = 1'b0;
    idle(6);
    apb_rd(0, A_STAT, rd); chk("R9 two-cycle pulse filtered", rd, 32'h0);
    @(negedge clk); pin_in[0] = 1'b1;
    idle(6); pin_in[0] = 1'b0;
    idle(6);
    apb_rd(0, A_STAT, rd); chk("R9 long pulse accepted", rd, 32'h1);
    apb_wr(0, A_DEB, 32'h0);
    apb_wr(0, A_EOI, 32'h1);
    @(negedge clk); pin_in[0] = 1'b1;
    @(negedge clk); pin_in[0] = 1'b0;
    idle(6);
    apb_rd(0, A_STAT, rd); chk("R9 unfiltered pulse latched", rd, 32'h1);
    apb_wr(0, A_EOI, 32'h1);

    // R10 edge and clear in the same cycle
    @(negedge clk); pin_in[0] = 1'b1;
    apb_wr(0, A_EOI, 32'h1);
    idle(2);
    apb_rd(0, A_STAT, rd); chk("R10 edge wins over clear", rd, 32'h1);
    apb_wr(0, A_EOI, 32'h1);
    apb_rd(0, A_STAT, rd); chk("R6 later clear works", rd, 32'h0);
    @(negedge clk); pin_in[0] = 1'b0;
    idle(4);

    // R11 alternate map
    apb_wr(1, 8'h30, 32'h1);
    apb_wr(1, 8'h34, 32'h1);
    apb_wr(1, 8'h38, 32'h1);
    apb_wr(1, 8'h44, 32'h2);
    apb_wr(1, 8'h48, 32'h5);
    apb_wr(1, 8'h40, 32'hFFFF_FFFF);
    apb_rd(1, 8'h44, rd); chk("R11 alt mask", rd, 32'h2);
    apb_rd(1, 8'h34, rd); chk("R11 alt type", rd, 32'h1);
    apb_rd(1, 8'h38, rd); chk("R11 alt polarity", rd, 32'h1);
    apb_rd(1, 8'h48, rd); chk("R11 alt debounce", rd, 32'h5);
    apb_wr(1, 8'h48, 32'h0);
    @(negedge clk); pin_in[0] = 1'b1;
    idle(5);
    apb_rd(1, 8'h3C, rd); chk("R11 alt status", rd, 32'h1);
    chk("R11 alt irq", {31'h0, irq_a}, 32'h1);
    apb_wr(1, 8'h40, 32'h1);
    apb_rd(1, 8'h3C, rd); chk("R11 alt eoi clears", rd, 32'h0);
    @(negedge clk); pin_in[0] = 1'b0;

    // R12 unmapped addresses
    apb_wr(0, 8'h08, 32'hFFFF_FFFF);
    apb_rd(0, 8'h08, rd); chk("R12 unmapped read 0x08", rd, 32'h0);
    apb_rd(0, 8'h2C, rd); chk("R12 unmapped read 0x2C", rd, 32'h0);
    apb_rd(0, 8'h60, rd); chk("R12 unmapped read 0x60", rd, 32'h0);
    for (int p = 0; p < NP; p++) begin
      apb_rd(0, a_dout(p), rd); chk("R12 dout untouched", rd, exp_dout[p]);
    end

    summary();
    $finish;
  end
endmodule